// File: doc/BRIEF.md
# Ancillary Packet Extractor

This block watches a parallel 10-bit video word stream, finds ancillary data packets wherever they appear in it, and keeps the ones that pass a type filter and a line filter. Each kept packet is copied whole, one byte per word, into the write half of a two-half byte buffer. A host reads the other half through a small address window. The halves change roles at every frame boundary, so the host always sees the packets of the frame that has just ended.

Extraction is gated in several ways. It stays off for a fixed number of clocks after the extraction mode is selected. It needs the host enable bit, the external processing-enable pin and the lock input to be high. It starts only on a frame boundary. Dropping any enable stops it at once, and it restarts only at a later frame boundary.

Top module: `ancPktExtract`

## Requirements
- R1: A packet starts at the word sequence 0x000, 0x3FF, 0x3FF, which is detected at any point of a frame except inside a packet being parsed. Payload words that form this sequence do not start a new packet.
- R2: A kept packet is stored as DC+7 bytes, where DC is bits 7:0 of the count word. The bytes are the low 8 bits of the three flag words, the DID word, the SDID word, the count word, the DC payload words and the checksum word. Packets are packed back to back from half offset 0, in arrival order.
- R3: Five type slots sit in `typeCfg`, slot k at bits 16k+15:16k and holding {DID[7:0], SDID[7:0]}. If all slots are zero, every type is kept. Otherwise a zero slot is unused and a packet is kept only if it equals a non-zero slot.
- R4: `lineA` and `lineB` restrict the lines on which packets are kept, using `lineNum` as sampled on the SDID word. When both are zero, every line is kept. A zero register takes no part in the match.
- R5: A read at `rdAddr` = 0x02C + k, for k from 0 to HALF_DEPTH-1, returns byte k of the read half on `rdData` one clock later. Any other address returns 0.
- R6: A read half location at or beyond the bytes stored during its frame reads as 0. After reset every location reads as 0.
- R7: Each `frameStart` pulse swaps the halves and empties the new write half. A packet still being parsed at that word is discarded.
- R8: A packet that would not fit into the bytes left in the write half is dropped whole. A packet that ends exactly at the last location is kept.
- R9: Nothing is written for INIT_CYCLES clocks after `modeExtract` goes high. The count starts again whenever `modeExtract` drops.
- R10: After `hostExtEn` is set, extraction starts at the next `frameStart` and not within the current frame.
- R11: While `procEnPin` is low, nothing is extracted, whatever `hostExtEn` says. After the pin returns high, extraction resumes only at a `frameStart`.
- R12: While `locked` is low, nothing is extracted. After lock returns, extraction resumes only at a `frameStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vidWord | input | WORD_W | Video word, one per clock |
| frameStart | input | 1 | High on the first word of a frame |
| lineNum | input | LINE_W | Line number of the current word |
| locked | input | 1 | Input stream is locked |
| procEnPin | input | 1 | External processing enable |
| modeExtract | input | 1 | Extraction mode selected |
| hostExtEn | input | 1 | Host extraction enable bit |
| typeCfg | input | 16*NUM_TYPES | Packet type slots |
| lineA | input | LINE_W | First selected line, 0 = unused |
| lineB | input | LINE_W | Second selected line, 0 = unused |
| rdAddr | input | ADDR_W | Host read address |
| rdData | output | 8 | Host read data, one clock after the address |

## Verification
Packet bytes are written during the frame in which they arrive. They become readable only after the next `frameStart` swaps the halves, so the bench checks each frame's packets in a read sweep that follows that frame's closing boundary. A read address is driven on one falling edge, and `rdData` is registered on the following rising edge and sampled on the falling edge after it, one clock later. Enable changes made partway through a frame take effect at the following `frameStart`, so each gating case is judged on the buffer of the frame during which the change was made. The read sweep runs two addresses past each end of the window, which covers the zero returns outside it.

// File: rtl/ancPkg.sv
package ancPkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 9;  // holds the longest packet, 255 + 7 bytes

  typedef enum logic [2:0] {
    PS_SEEK, PS_DID, PS_SDID, PS_DC, PS_DATA, PS_CS
  } parseState_t;

  // strobes from the control to the buffer datapath
  typedef struct packed {
    logic              swap;
    logic              wrEn;
    logic [OFF_W-1:0]  wrOff;
    logic [BYTE_W-1:0] wrByte;
    logic              commit;
    logic [OFF_W-1:0]  commitLen;
  } ancStrobe_t;
endpackage

// File: rtl/ancFilter.sv
module ancFilter #(
  parameter int NUM_TYPES = 5,
  parameter int LINE_W    = 11
) (
  input  logic [16*NUM_TYPES-1:0] cfgTypes,
  input  logic [LINE_W-1:0]       cfgLineA,
  input  logic [LINE_W-1:0]       cfgLineB,
  input  logic [7:0]              pktDid,
  input  logic [7:0]              pktSdid,
  input  logic [LINE_W-1:0]       pktLine,
  output logic                    pass
);
  logic [NUM_TYPES-1:0] slotUsed;
  logic [NUM_TYPES-1:0] slotHit;

  for (genvar k = 0; k < NUM_TYPES; k++) begin : gSlot
    assign slotUsed[k] = |cfgTypes[16*k +: 16];
    assign slotHit[k]  = slotUsed[k] && (cfgTypes[16*k +: 16] == {pktDid, pktSdid});
  end

  logic typeOk, lineOk, lineAUsed, lineBUsed;
  always_comb begin
    lineAUsed = |cfgLineA;
    lineBUsed = |cfgLineB;
    typeOk    = (slotUsed == '0) || (|slotHit);
    lineOk    = (!lineAUsed && !lineBUsed)
             || (lineAUsed && (pktLine == cfgLineA))
             || (lineBUsed && (pktLine == cfgLineB));
    pass      = typeOk && lineOk;
  end
endmodule

// File: rtl/ancCtrl.sv
module ancCtrl
  import ancPkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int LINE_W      = 11,
  parameter int NUM_TYPES   = 5,
  parameter int HALF_DEPTH  = 1024,
  parameter int INIT_CYCLES = 2200,
  parameter int FILL_W      = $clog2(HALF_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WORD_W-1:0]       vidWord,
  input  logic                    frameStart,
  input  logic [LINE_W-1:0]       lineNum,
  input  logic                    locked,
  input  logic                    procEnPin,
  input  logic                    modeExtract,
  input  logic                    hostExtEn,
  input  logic [16*NUM_TYPES-1:0] typeCfg,
  input  logic [LINE_W-1:0]       lineA,
  input  logic [LINE_W-1:0]       lineB,
  input  logic [FILL_W-1:0]       wrFill,
  output ancStrobe_t              strobe
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 2);
  localparam int SUM_W = ((FILL_W > OFF_W) ? FILL_W : OFF_W) + 1;

  // mode-entry delay counter
  logic [CNT_W-1:0] initCnt;
  logic             initDone;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                initCnt <= '0;
    else if (!modeExtract)                    initCnt <= '0;
    else if (initCnt != CNT_W'(INIT_CYCLES))  initCnt <= initCnt + CNT_W'(1);
  end
  assign initDone = (initCnt == CNT_W'(INIT_CYCLES));

  // frame-aligned enable
  logic armReq, activeQ, activeNow;
  assign armReq    = modeExtract && procEnPin && hostExtEn && locked && initDone;
  assign activeNow = armReq && (activeQ || frameStart);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeQ <= 1'b0;
    else       activeQ <= activeNow;
  end

  // word classification
  logic [7:0] wordByte;
  logic       isZero, isOnes;
  assign wordByte = vidWord[7:0];
  assign isZero   = (vidWord == '0);
  assign isOnes   = &vidWord;

  // parser state
  parseState_t state, nState;
  logic [1:0]       prog, nProg;
  logic [7:0]       didQ, nDid;
  logic [7:0]       remQ, nRem;
  logic [OFF_W-1:0] offQ, nOff;
  logic [OFF_W-1:0] lenQ, nLen;

  logic filterPass, fitOk;
  ancFilter #(.NUM_TYPES(NUM_TYPES), .LINE_W(LINE_W)) uFilter (
    .cfgTypes(typeCfg), .cfgLineA(lineA), .cfgLineB(lineB),
    .pktDid(didQ), .pktSdid(wordByte), .pktLine(lineNum), .pass(filterPass)
  );

  assign fitOk = (SUM_W'(wrFill) + SUM_W'(wordByte) + SUM_W'(7)) <= SUM_W'(HALF_DEPTH);

  always_comb begin
    strobe        = '0;
    strobe.swap   = frameStart;
    strobe.wrByte = wordByte;
    nState = state;
    nProg  = prog;
    nDid   = didQ;
    nRem   = remQ;
    nOff   = offQ;
    nLen   = lenQ;
    if (!activeNow || (frameStart && state != PS_SEEK)) begin
      nState = PS_SEEK;
      nProg  = 2'd0;
    end else begin
      unique case (state)
        PS_SEEK: begin
          if (isZero) begin
            strobe.wrEn = 1'b1; strobe.wrOff = OFF_W'(0); nProg = 2'd1;
          end else if (isOnes && prog == 2'd1) begin
            strobe.wrEn = 1'b1; strobe.wrOff = OFF_W'(1); nProg = 2'd2;
          end else if (isOnes && prog == 2'd2) begin
            strobe.wrEn = 1'b1; strobe.wrOff = OFF_W'(2); nProg = 2'd0;
            nState = PS_DID;
          end else begin
            nProg = 2'd0;
          end
        end
        PS_DID: begin
          strobe.wrEn = 1'b1; strobe.wrOff = OFF_W'(3);
          nDid   = wordByte;
          nState = PS_SDID;
        end
        PS_SDID: begin
          strobe.wrEn = 1'b1; strobe.wrOff = OFF_W'(4);
          nState = filterPass ? PS_DC : PS_SEEK;
        end
        PS_DC: begin
          if (fitOk) begin
            strobe.wrEn = 1'b1; strobe.wrOff = OFF_W'(5);
            nRem   = wordByte;
            nLen   = OFF_W'(wordByte) + OFF_W'(7);
            nOff   = OFF_W'(6);
            nState = (wordByte == 8'd0) ? PS_CS : PS_DATA;
          end else begin
            nState = PS_SEEK;
          end
        end
        PS_DATA: begin
          strobe.wrEn = 1'b1; strobe.wrOff = offQ;
          nOff = offQ + OFF_W'(1);
          nRem = remQ - 8'd1;
          if (remQ == 8'd1) nState = PS_CS;
        end
        PS_CS: begin
          strobe.wrEn      = 1'b1;
          strobe.wrOff     = offQ;
          strobe.commit    = 1'b1;
          strobe.commitLen = lenQ;
          nState = PS_SEEK;
          nProg  = 2'd0;
        end
        default: begin
          nState = PS_SEEK;
          nProg  = 2'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PS_SEEK;
      prog  <= 2'd0;
      didQ  <= '0;
      remQ  <= '0;
      offQ  <= '0;
      lenQ  <= '0;
    end else begin
      state <= nState;
      prog  <= nProg;
      didQ  <= nDid;
      remQ  <= nRem;
      offQ  <= nOff;
      lenQ  <= nLen;
    end
  end
endmodule

// File: rtl/ancDatapath.sv
module ancDatapath
  import ancPkg::*;
#(
  parameter int HALF_DEPTH = 1024,
  parameter int ADDR_W     = 12,
  parameter int READ_BASE  = 44,
  parameter int FILL_W     = $clog2(HALF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ancStrobe_t        strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [FILL_W-1:0] wrFill
);
  localparam int HALF_AW = $clog2(HALF_DEPTH);
  localparam int SUM_W   = ((FILL_W > OFF_W) ? FILL_W : OFF_W) + 1;

  logic [7:0]        mem [2*HALF_DEPTH];
  logic              wrHalf, rdHalf;
  logic [FILL_W-1:0] fillQ [2];
  logic [FILL_W-1:0] curFill;

  assign rdHalf  = ~wrHalf;
  assign curFill = fillQ[wrHalf];
  assign wrFill  = curFill;

  // a write in the swap cycle already lands in the new half
  logic              wHalf;
  logic [FILL_W-1:0] wBase;
  logic [SUM_W-1:0]  wAddr;
  logic              wOk;
  always_comb begin
    wHalf = strobe.swap ? ~wrHalf : wrHalf;
    wBase = strobe.swap ? '0 : curFill;
    wAddr = SUM_W'(wBase) + SUM_W'(strobe.wrOff);
    wOk   = strobe.wrEn && (wAddr < SUM_W'(HALF_DEPTH));
  end

  always_ff @(posedge clk) begin
    if (wOk) mem[{wHalf, wAddr[HALF_AW-1:0]}] <= strobe.wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrHalf   <= 1'b0;
      fillQ[0] <= '0;
      fillQ[1] <= '0;
    end else if (strobe.swap) begin
      wrHalf        <= ~wrHalf;
      fillQ[rdHalf] <= '0;
    end else if (strobe.commit) begin
      fillQ[wrHalf] <= curFill + FILL_W'(strobe.commitLen);
    end
  end

  // host read port, one clock latency, zero outside stored content
  logic [ADDR_W-1:0] rdOff;
  logic              inRange, present;
  always_comb begin
    rdOff   = rdAddr - ADDR_W'(READ_BASE);
    inRange = (32'(rdAddr) >= READ_BASE) && (32'(rdOff) < HALF_DEPTH);
    present = inRange && (32'(rdOff) < 32'(fillQ[rdHalf]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (present) rdData <= mem[{rdHalf, rdOff[HALF_AW-1:0]}];
    else              rdData <= '0;
  end
endmodule

// File: rtl/ancPktExtract.sv
module ancPktExtract
  import ancPkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int LINE_W      = 11,
  parameter int NUM_TYPES   = 5,
  parameter int HALF_DEPTH  = 1024,
  parameter int INIT_CYCLES = 2200,
  parameter int ADDR_W      = 12,
  parameter int READ_BASE   = 44
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WORD_W-1:0]       vidWord,
  input  logic                    frameStart,
  input  logic [LINE_W-1:0]       lineNum,
  input  logic                    locked,
  input  logic                    procEnPin,
  input  logic                    modeExtract,
  input  logic                    hostExtEn,
  input  logic [16*NUM_TYPES-1:0] typeCfg,
  input  logic [LINE_W-1:0]       lineA,
  input  logic [LINE_W-1:0]       lineB,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [7:0]              rdData
);
  localparam int FILL_W = $clog2(HALF_DEPTH + 1);

  ancStrobe_t        strobe;
  logic [FILL_W-1:0] wrFill;

  ancCtrl #(
    .WORD_W(WORD_W), .LINE_W(LINE_W), .NUM_TYPES(NUM_TYPES),
    .HALF_DEPTH(HALF_DEPTH), .INIT_CYCLES(INIT_CYCLES), .FILL_W(FILL_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .vidWord(vidWord), .frameStart(frameStart),
    .lineNum(lineNum), .locked(locked), .procEnPin(procEnPin),
    .modeExtract(modeExtract), .hostExtEn(hostExtEn), .typeCfg(typeCfg),
    .lineA(lineA), .lineB(lineB), .wrFill(wrFill), .strobe(strobe)
  );

  ancDatapath #(
    .HALF_DEPTH(HALF_DEPTH), .ADDR_W(ADDR_W), .READ_BASE(READ_BASE), .FILL_W(FILL_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr),
    .rdData(rdData), .wrFill(wrFill)
  );
endmodule

// File: rtl/ancPktExtractChk.sv
module ancPktExtractChk #(
  parameter int HALF_DEPTH  = 1024,
  parameter int INIT_CYCLES = 2200,
  parameter int ADDR_W      = 12,
  parameter int READ_BASE   = 44,
  parameter int FILL_W      = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeExtract,
  input logic              procEnPin,
  input logic              locked,
  input logic              frameStart,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic              wrEn,
  input logic [FILL_W-1:0] wrFill
);
  localparam int MC_W = $clog2(INIT_CYCLES + 2);

  // clocks spent in extraction mode, saturating
  logic [MC_W-1:0] modeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              modeCnt <= '0;
    else if (!modeExtract)                  modeCnt <= '0;
    else if (32'(modeCnt) < INIT_CYCLES)    modeCnt <= modeCnt + MC_W'(1);
  end

  logic outOfWindow;
  assign outOfWindow = (32'(rdAddr) < READ_BASE) || (32'(rdAddr) >= READ_BASE + HALF_DEPTH);

  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (32'(modeCnt) < INIT_CYCLES) |-> !wrEn);                    // R9
  AST_PIN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !procEnPin |-> !wrEn);                                      // R11
  AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> !wrEn);                                         // R12
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    32'(wrFill) <= HALF_DEPTH);                                 // R8
  AST_SWAP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (wrFill == '0));                             // R7
  AST_READ_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outOfWindow |=> (rdData == 8'd0));                          // R5
endmodule

bind ancPktExtract ancPktExtractChk #(
  .HALF_DEPTH(HALF_DEPTH), .INIT_CYCLES(INIT_CYCLES), .ADDR_W(ADDR_W),
  .READ_BASE(READ_BASE), .FILL_W(FILL_W)
) uChk (
  .clk(clk), .rstN(rstN), .modeExtract(modeExtract), .procEnPin(procEnPin),
  .locked(locked), .frameStart(frameStart), .rdAddr(rdAddr), .rdData(rdData),
  .wrEn(strobe.wrEn), .wrFill(wrFill)
);

// File: tb/ancPktExtract_test.sv
module ancPktExtract_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 1024;
  localparam int BASE       = 44;
  localparam int NT         = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  vidWord = 10'h040;
  logic        frameStart = 1'b0;
  logic [10:0] lineNum = '0;
  logic        locked = 1'b0, procEnPin = 1'b0, modeExtract = 1'b0, hostExtEn = 1'b0;
  logic [16*NT-1:0] typeCfg = '0;
  logic [10:0] lineA = '0, lineB = '0;
  logic [11:0] rdAddr = '0;
  logic [7:0]  rdData;

  always #(CLK_PERIOD/2) clk = ~clk;

  ancPktExtract uut (
    .clk(clk), .rstN(rstN), .vidWord(vidWord), .frameStart(frameStart),
    .lineNum(lineNum), .locked(locked), .procEnPin(procEnPin),
    .modeExtract(modeExtract), .hostExtEn(hostExtEn), .typeCfg(typeCfg),
    .lineA(lineA), .lineB(lineB), .rdAddr(rdAddr), .rdData(rdData)
  );

  int nChecks = 0, nFails = 0;
  logic [7:0] curExp [HALF];
  logic [7:0] prevExp [HALF];
  int curFill = 0, prevFill = 0;
  bit frameEn = 1'b0;
  string curTag = "R6", prevTag = "R6";

  task automatic checkByte(input string req, input int addr, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s addr=%03h actual=%02h expected=%02h", req, addr, act, exp);
    end
  endtask

  function automatic bit typeOk(input logic [7:0] d, input logic [7:0] s);
    bit any = 1'b0, hit = 1'b0;
    for (int k = 0; k < NT; k++) begin
      if (typeCfg[16*k +: 16] != 16'h0) begin
        any = 1'b1;
        if (typeCfg[16*k +: 16] == {d, s}) hit = 1'b1;
      end
    end
    return !any || hit;
  endfunction

  function automatic bit lineOk(input int ln);
    if (lineA == 0 && lineB == 0) return 1'b1;
    return (lineA != 0 && ln == int'(lineA)) || (lineB != 0 && ln == int'(lineB));
  endfunction

  task automatic putWord(input logic [9:0] w);
    @(negedge clk);
    vidWord = w;
  endtask

  // cut > 0 sends only the first cut words of the packet
  task automatic sendPkt(input logic [7:0] did, input logic [7:0] sdid, input logic [7:0] dc,
                         input int line, input bit tricky = 1'b0, input int cut = 0);
    logic [9:0] words [262];
    int len, nSend;
    bit store;
    len = int'(dc) + 7;
    words[0] = 10'h000; words[1] = 10'h3FF; words[2] = 10'h3FF;
    words[3] = {2'b10, did}; words[4] = {2'b10, sdid}; words[5] = {2'b10, dc};
    for (int k = 0; k < int'(dc); k++) begin
      if (tricky) words[6+k] = (k % 3 == 0) ? 10'h000 : 10'h3FF;
      else        words[6+k] = {2'b01, 8'(int'(did) + 13*k + 1)};
    end
    words[len-1] = {2'b01, did ^ sdid ^ dc};
    store = frameEn && (cut == 0) && typeOk(did, sdid) && lineOk(line) && (curFill + len <= HALF);
    nSend = (cut > 0) ? cut : len;
    @(negedge clk);
    lineNum = 11'(line);
    vidWord = words[0];
    for (int i = 1; i < nSend; i++) putWord(words[i]);
    if (store) begin
      for (int i = 0; i < len; i++) curExp[curFill + i] = words[i][7:0];
      curFill += len;
    end
    if (cut == 0) begin
      putWord(10'h040);
      putWord(10'h040);
    end
  endtask

  task automatic verifyPrev();
    logic [7:0] e;
    string r;
    for (int a = BASE - 2; a < BASE + HALF + 2; a++) begin
      @(negedge clk);
      rdAddr = 12'(a);
      @(negedge clk);
      if (a < BASE || a >= BASE + HALF) begin
        e = 8'h00; r = "R5";
      end else if (a - BASE >= prevFill) begin
        e = 8'h00; r = "R6";
      end else begin
        e = prevExp[a - BASE]; r = prevTag;
      end
      checkByte(r, a, rdData, e);
    end
  endtask

  task automatic newFrame(input bit en, input string tag);
    @(negedge clk);
    frameStart = 1'b1;
    vidWord    = 10'h040;
    @(negedge clk);
    frameStart = 1'b0;
    prevExp  = curExp;
    prevFill = curFill;
    for (int i = 0; i < HALF; i++) curExp[i] = 8'h00;
    curFill = 0;
    prevTag = curTag;
    curTag  = tag;
    frameEn = en;
    verifyPrev();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < HALF; i++) curExp[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // reset state: window start reads zero (R5, R6)
    @(negedge clk); rdAddr = 12'h02C;
    @(negedge clk); checkByte("R5", 12'h02C, rdData, 8'h00);

    modeExtract = 1'b1; procEnPin = 1'b1; locked = 1'b1; hostExtEn = 1'b1;
    // F0 inside the mode-entry delay: nothing kept (R9)
    newFrame(1'b0, "R9");
    sendPkt(8'h45, 8'h01, 8'd4, 10);
    repeat (2300) @(negedge clk);
    // F1: host bit off at the boundary, set partway through (R10)
    hostExtEn = 1'b0;
    newFrame(1'b0, "R10");
    sendPkt(8'h45, 8'h01, 8'd2, 10);
    hostExtEn = 1'b1;
    sendPkt(8'h46, 8'h02, 8'd3, 11);
    // F2: all types and lines, flag detection and payload look-alikes (R1, R2)
    newFrame(1'b1, "R1");
    sendPkt(8'h45, 8'h01, 8'd0, 5);
    putWord(10'h000); putWord(10'h3FF); putWord(10'h040);
    sendPkt(8'h60, 8'h60, 8'd1, 6);
    putWord(10'h000); putWord(10'h000); putWord(10'h3FF);
    sendPkt(8'h10, 8'h20, 8'd5, 7);
    sendPkt(8'h77, 8'h01, 8'd9, 8, 1'b1);
    sendPkt(8'h05, 8'h06, 8'd255, 9);
    // F3: type slots 1 and 3 in use (R3)
    typeCfg[16*1 +: 16] = 16'h4105;
    typeCfg[16*3 +: 16] = 16'h6060;
    newFrame(1'b1, "R3");
    sendPkt(8'h41, 8'h05, 8'd3, 1);
    sendPkt(8'h41, 8'h06, 8'd3, 1);
    sendPkt(8'h60, 8'h60, 8'd2, 1);
    sendPkt(8'h12, 8'h34, 8'd2, 1);
    sendPkt(8'h05, 8'h41, 8'd2, 1);
    // F4..F6: line selection (R4)
    typeCfg = '0;
    lineA = 11'd20; lineB = 11'd0;
    newFrame(1'b1, "R4");
    sendPkt(8'h21, 8'h01, 8'd2, 19);
    sendPkt(8'h22, 8'h02, 8'd2, 20);
    sendPkt(8'h23, 8'h03, 8'd2, 21);
    sendPkt(8'h24, 8'h04, 8'd1, 20);
    lineA = 11'd0; lineB = 11'd300;
    newFrame(1'b1, "R4");
    sendPkt(8'h31, 8'h01, 8'd2, 300);
    sendPkt(8'h32, 8'h02, 8'd2, 20);
    sendPkt(8'h33, 8'h03, 8'd2, 299);
    lineA = 11'd7; lineB = 11'd9;
    newFrame(1'b1, "R4");
    sendPkt(8'h41, 8'h11, 8'd2, 7);
    sendPkt(8'h42, 8'h12, 8'd2, 8);
    sendPkt(8'h43, 8'h13, 8'd2, 9);
    // F7: overflow, dropped whole, exact fit kept (R8)
    lineA = 11'd0; lineB = 11'd0;
    newFrame(1'b1, "R8");
    for (int i = 0; i < 4; i++) sendPkt(8'(8'h50 + i), 8'h01, 8'd255, 3);
    sendPkt(8'h55, 8'h01, 8'd200, 3);
    sendPkt(8'h56, 8'h01, 8'd24, 3);
    sendPkt(8'h57, 8'h01, 8'd0, 3);
    // F8: pin low, host bit ignored, no restart mid-frame (R11)
    procEnPin = 1'b0;
    newFrame(1'b0, "R11");
    sendPkt(8'h61, 8'h01, 8'd2, 3);
    procEnPin = 1'b1;
    sendPkt(8'h62, 8'h01, 8'd2, 3);
    // F9: unlocked, no restart mid-frame (R12)
    locked = 1'b0;
    newFrame(1'b0, "R12");
    sendPkt(8'h63, 8'h01, 8'd2, 3);
    locked = 1'b1;
    sendPkt(8'h64, 8'h01, 8'd2, 3);
    // F10: a complete packet, then one cut short by the next boundary (R7)
    newFrame(1'b1, "R7");
    sendPkt(8'h71, 8'h02, 8'd4, 3);
    sendPkt(8'h72, 8'h02, 8'd20, 3, 1'b0, 9);
    // F11: fresh half after the swap (R2)
    newFrame(1'b1, "R2");
    sendPkt(8'h73, 8'h03, 8'd6, 4);
    newFrame(1'b1, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule